// File: doc/BRIEF.md
# Predicated Signed Rounding Vector Shifter

This block is a lane-parallel execution unit for a vector datapath. One operand vector holds signed per-lane shift counts and also gives the value that inactive lanes keep. The other operand vector holds the signed elements to be shifted. A per-byte predicate decides which lanes are active. In an active lane, a positive count shifts the element left. A zero or negative count does an arithmetic right shift by the negated count, rounded half up. Inactive lanes pass the count vector's lane through unchanged, so the result can be written back to the register that supplied the counts.

The lane width is chosen per issue by a two-bit size code. The vector length is a parameter. An issue strobe launches one operation, and the result appears registered on the next cycle together with a one-cycle valid pulse. There is no handshake.

Top module: `vrshl_unit`

## Requirements
- R1: `size_i` selects the lane width 8 << `size_i`: code 0 gives 8-bit lanes, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*EW +: EW] of every vector.
- R2: The shift count of lane k is the signed value of lane k of `shamt_vec_i`. A count c > 0 gives `data << c`. A count c <= 0 gives an arithmetic right shift by -c, where a count of 0 returns the element unchanged.
- R3: A right shift by n >= 1 adds 2^(n-1) to the sign-extended element before shifting. This rounds half up: with 8-bit lanes, 5 shifted by -1 gives 3 and -5 shifted by -1 gives -2 (0xFE).
- R4: A left shift keeps only the low EW bits of the result, with no saturation. For example, 0x41 shifted by 2 in an 8-bit lane gives 0x04.
- R5: A count of EW or more gives 0. A count of -EW or less also gives 0. Counts as far out as the most negative and most positive lane value behave the same way.
- R6: The rounding add keeps its carry. With 8-bit lanes, 127 shifted by -1 gives 64, and -128 shifted by -7 gives -1 (0xFF).
- R7: Lane k is active when predicate bit k*EW/8 of `pred_i` is 1. An inactive lane outputs lane k of `shamt_vec_i` unchanged.
- R8: With `pred_i` all zero, the result equals `shamt_vec_i` whatever `data_vec_i` holds.
- R9: `valid_o` is high exactly in the cycle after each cycle with `issue_i` high, and the result of that issue is on `result_o` at the same time. Back-to-back issues give back-to-back results.
- R10: While `issue_i` is low, `result_o` holds its last value.
- R11: After reset, `valid_o` is 0 and `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Launch one operation this cycle |
| size_i | input | 2 | Lane width code |
| shamt_vec_i | input | VB | Per-lane signed shift counts and old destination contents |
| data_vec_i | input | VB | Per-lane signed elements to shift |
| pred_i | input | VB/8 | One predicate bit per vector byte |
| result_o | output | VB | Registered result vector |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Directed issues use hand-worked values, one group for each effect:
- Odd elements shifted right by one expose the half-up rounding and the sign of the rounding.
- The most positive element shows whether the carry of the rounding add is lost.
- A left shift past the top bit shows wrap against saturation.
- Counts of exactly ±EW and ±(EW+1), and the extreme lane values, separate a correct clamp from an off-by-one.

Predicate patterns include all-zero input, alternating bytes and lone bits that fall inside a wide lane but not on its lowest byte. These show whether the right predicate bit is used. Several hundred random issues cover all four sizes with counts biased toward the extremes. They run back to back and with gaps, which shows that valid timing and result holding are separate from the data path.

// File: rtl/vrshl_pkg.sv
package vrshl_pkg;

  localparam int unsigned NUM_SIZES = 4;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  // lane width in bits for a size code
  function automatic int unsigned lane_bits(int unsigned code);
    return 8 << code;
  endfunction

  // number of lanes of a given width in a vector
  function automatic int unsigned lane_count(int unsigned vb, int unsigned code);
    return vb / lane_bits(code);
  endfunction

endpackage

// File: rtl/vrshl_lane.sv
module vrshl_lane #(
  parameter int unsigned EW = 8
) (
  input  logic          active_i,
  input  logic [EW-1:0] data_i,
  input  logic [EW-1:0] amt_i,
  output logic [EW-1:0] res_o
);
  // datapath wide enough that the rounding carry survives
  localparam int unsigned W  = EW + 2;
  // signed width holding -(EW+1)..(EW+1)
  localparam int unsigned CW = $clog2(EW + 2) + 1;
  localparam logic signed [EW-1:0] LIM_POS = EW'(EW + 1);
  localparam logic signed [EW-1:0] LIM_NEG = -EW'(EW + 1);
  localparam logic [CW-1:0] EW_C = CW'(EW);

  function automatic logic signed [CW-1:0] clamp_amt(logic signed [EW-1:0] a);
    if (a > LIM_POS) return CW'(EW + 1);
    if (a < LIM_NEG) return -CW'(EW + 1);
    return a[CW-1:0];
  endfunction

  function automatic logic signed [W-1:0] round_const(logic [CW-1:0] n);
    if (n == '0) return '0;
    return W'(1) << (n - CW'(1));
  endfunction

  function automatic logic [EW-1:0] shr_trunc(logic signed [W-1:0] v, logic [CW-1:0] n);
    return EW'(v >>> n);
  endfunction

  // named internal events for checking
  logic signed [CW-1:0] amt_c;
  logic                 dir_left;
  logic [CW-1:0]        mag;
  logic signed [W-1:0]  ext;
  logic signed [W-1:0]  rnd_sum;
  logic [EW-1:0]        left_val;
  logic [EW-1:0]        right_val;
  logic [EW-1:0]        shift_val;

  assign amt_c    = clamp_amt(amt_i);
  assign dir_left = (amt_c > 0);
  assign mag      = dir_left ? amt_c : -amt_c;
  assign ext      = {{2{data_i[EW-1]}}, data_i};
  assign rnd_sum  = ext + round_const(mag);
  assign left_val = data_i << mag;
  assign right_val = shr_trunc(rnd_sum, mag);
  assign shift_val = dir_left ? left_val : right_val;
  assign res_o    = active_i ? shift_val : amt_i;

  always_comb begin
    if (dir_left && mag >= EW_C)
      assert_big_left_zero_R5: assert (shift_val == '0)
        else $error("left shift beyond lane width not zero");
    if (!dir_left && mag >= EW_C)
      assert_far_right_zero_R5: assert (shift_val == '0)
        else $error("right shift beyond lane width not zero");
    if (!dir_left && mag == CW'(1) && data_i == {1'b0, {(EW-1){1'b1}}})
      assert_round_carry_kept_R6: assert (shift_val == (EW'(1) << (EW - 2)))
        else $error("rounding carry lost");
  end

endmodule

// File: rtl/vrshl_slice.sv
module vrshl_slice #(
  parameter int unsigned EW = 8,
  parameter int unsigned VB = 128
) (
  input  logic [VB-1:0]    data_vec_i,
  input  logic [VB-1:0]    amt_vec_i,
  input  logic [VB/EW-1:0] lane_act_i,
  output logic [VB-1:0]    res_vec_o
);
  localparam int unsigned NL = VB / EW;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    vrshl_lane #(.EW(EW)) i_lane (
      .active_i (lane_act_i[k]),
      .data_i   (data_vec_i[k*EW +: EW]),
      .amt_i    (amt_vec_i[k*EW +: EW]),
      .res_o    (res_vec_o[k*EW +: EW])
    );
  end

endmodule

// File: rtl/vrshl_unit.sv
module vrshl_unit
  import vrshl_pkg::*;
#(
  parameter int unsigned VB = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [1:0]    size_i,
  input  logic [VB-1:0] shamt_vec_i,
  input  logic [VB-1:0] data_vec_i,
  input  logic [VB/8-1:0] pred_i,
  output logic [VB-1:0] result_o,
  output logic          valid_o
);
  localparam int unsigned NB = VB / 8;

  logic          any_active;
  logic [VB-1:0] data_eff;
  logic [VB-1:0] cand [NUM_SIZES];
  logic [VB-1:0] comb_res;

  // with no active lane the data operand is treated as zero
  assign any_active = |pred_i;
  assign data_eff   = any_active ? data_vec_i : '0;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned EW = lane_bits(s);
    localparam int unsigned NL = lane_count(VB, s);
    logic [NL-1:0] act;
    logic [VB-1:0] res;

    for (genvar k = 0; k < NL; k++) begin : g_pick
      assign act[k] = pred_i[k * (EW / 8)];
    end

    vrshl_slice #(.EW(EW), .VB(VB)) i_slice (
      .data_vec_i (data_eff),
      .amt_vec_i  (shamt_vec_i),
      .lane_act_i (act),
      .res_vec_o  (res)
    );
    assign cand[s] = res;
  end

  always_comb begin
    case (esize_e'(size_i))
      ESZ_8:   comb_res = cand[0];
      ESZ_16:  comb_res = cand[1];
      ESZ_32:  comb_res = cand[2];
      default: comb_res = cand[3];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= issue_i;
      if (issue_i) result_o <= comb_res;
    end
  end

  assert_valid_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> valid_o);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !valid_o);
  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(result_o));
  assert_all_inactive_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && pred_i == '0) |=> result_o == $past(shamt_vec_i));
  assert_inactive_byte_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && size_i == 2'd0 && !pred_i[0]) |=> result_o[7:0] == $past(shamt_vec_i[7:0]));

  if (NB * 8 != VB || VB % 64 != 0) begin : g_bad_vb
    initial $error("VB must be a multiple of 64");
  end

endmodule

// File: tb/test_vrshl_unit.sv
module test_vrshl_unit;
  localparam int VB = 128;
  localparam int NB = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_i = 1'b0;
  logic [1:0]    size_i = '0;
  logic [VB-1:0] shamt_vec_i = '0;
  logic [VB-1:0] data_vec_i = '0;
  logic [NB-1:0] pred_i = '0;
  logic [VB-1:0] result_o;
  logic          valid_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [VB-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  vrshl_unit #(.VB(VB)) i_vrshl_unit (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .size_i(size_i),
    .shamt_vec_i(shamt_vec_i), .data_vec_i(data_vec_i), .pred_i(pred_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  task automatic check(bit ok, string tag, logic [VB-1:0] act, logic [VB-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference for one lane: early exits instead of clamping
  function automatic logic [63:0] ref_lane(int ew, logic [63:0] d, logic [63:0] a);
    logic signed [127:0] x, s;
    logic [63:0] r;
    int n;
    x = {64'd0, d} << (128 - ew);
    x = x >>> (128 - ew);
    s = {64'd0, a} << (128 - ew);
    s = s >>> (128 - ew);
    if (s > 0) begin
      if (s >= ew) return 64'd0;
      n = int'(s);
      x = x << n;
    end else begin
      if (s < -ew) n = ew + 1;
      else n = int'(-s);
      if (n > 0) x = x + (128'sd1 <<< (n - 1));
      x = x >>> n;
    end
    r = x[63:0];
    if (ew < 64) r = r & ((64'd1 << ew) - 64'd1);
    return r;
  endfunction

  function automatic logic [VB-1:0] ref_vec(int sz, logic [VB-1:0] dst,
                                            logic [VB-1:0] dat, logic [NB-1:0] pr);
    logic [VB-1:0] o;
    int ew;
    ew = 8 << sz;
    o = dst;
    for (int k = 0; k < VB / ew; k++) begin
      logic [63:0] d, a, r;
      d = '0; a = '0;
      for (int b = 0; b < ew; b++) begin
        d[b] = dat[k*ew + b];
        a[b] = dst[k*ew + b];
      end
      if (pr[k*ew/8]) begin
        r = ref_lane(ew, d, a);
        for (int b = 0; b < ew; b++) o[k*ew + b] = r[b];
      end
    end
    return o;
  endfunction

  // driver: issue for one cycle and push the expectation
  task automatic do_issue(int sz, logic [VB-1:0] dst, logic [VB-1:0] dat,
                          logic [NB-1:0] pr, string tag);
    size_i      = 2'(sz);
    shamt_vec_i = dst;
    data_vec_i  = dat;
    pred_i      = pr;
    issue_i     = 1'b1;
    exp_q.push_back(ref_vec(sz, dst, dat, pr));
    tag_q.push_back(tag);
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  // monitor: compare each result against the queue head
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected valid", result_o, '0);
      end else begin
        logic [VB-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result_o === e, t, result_o, e);
      end
    end
  end

  function automatic logic [VB-1:0] fill(int ew, logic [63:0] v);
    logic [VB-1:0] o;
    for (int i = 0; i < VB; i++) o[i] = v[i % ew];
    return o;
  endfunction

  function automatic logic [63:0] pick_amt(int ew);
    int c;
    c = $urandom_range(0, 7);
    case (c)
      0: return 64'(ew);
      1: return -64'(ew);
      2: return 64'(ew + 1);
      3: return -64'(ew + 1);
      4: return 64'(-(ew + 3)) + 64'($urandom_range(0, 2 * ew + 6));
      5: return {$urandom(), $urandom()};
      6: return 64'd0;
      default: return -64'd1;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [VB-1:0] held;
    logic [NB-1:0] all1;
    all1 = '1;
    @(negedge clk);
    @(negedge clk);
    // R11 reset state
    check(valid_o === 1'b0, "R11 valid in reset", {127'd0, valid_o}, '0);
    check(result_o === '0, "R11 result in reset", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 rounding half up
    do_issue(0, fill(8, 64'hFF), fill(8, 64'h05), all1, "R3 5>>1");
    do_issue(0, fill(8, 64'hFF), fill(8, 64'hFB), all1, "R3 -5>>1");
    // R6 carry kept
    do_issue(0, fill(8, 64'hFF), fill(8, 64'h7F), all1, "R6 127>>1");
    do_issue(0, fill(8, 64'hF9), fill(8, 64'h80), all1, "R6 -128>>7");
    // R4 wrap on left
    do_issue(0, fill(8, 64'h02), fill(8, 64'h41), all1, "R4 wrap");
    // R2 zero count and plain left
    do_issue(1, fill(16, 64'h0000), fill(16, 64'h8123), all1, "R2 zero count");
    do_issue(1, fill(16, 64'h0003), fill(16, 64'hF001), all1, "R2 left 3");
    // R5 extremes
    do_issue(0, fill(8, 64'h08), fill(8, 64'h7F), all1, "R5 left ew");
    do_issue(0, fill(8, 64'hF8), fill(8, 64'h80), all1, "R5 right ew");
    do_issue(0, fill(8, 64'h80), fill(8, 64'h80), all1, "R5 right max");
    do_issue(0, fill(8, 64'h7F), fill(8, 64'h01), all1, "R5 left max");
    do_issue(3, fill(64, 64'h41), fill(64, 64'h1), all1, "R5 left ew+1");
    do_issue(3, fill(64, -64'd65), fill(64, 64'h8000_0000_0000_0000), all1, "R5 right ew+1");
    // R1 each width
    do_issue(1, fill(16, 64'hFFF8), fill(16, 64'h0180), all1, "R1 16-bit");
    do_issue(2, fill(32, 64'hFFFF_FFF0), fill(32, 64'h0001_8000), all1, "R1 32-bit");
    do_issue(3, fill(64, 64'd63), fill(64, 64'd1), all1, "R1 64-bit");
    // R7 predicate selection
    do_issue(0, fill(8, 64'hFF), fill(8, 64'h11), 16'hAAAA, "R7 alternate bytes");
    do_issue(2, fill(32, 64'h1), fill(32, 64'h3), 16'h2222, "R7 non-lowest byte");
    do_issue(3, fill(64, 64'h1), fill(64, 64'h3), 16'h0100, "R7 upper lane");
    // R8 nothing active
    do_issue(0, {4{32'hDEAD_BEEF}}, {4{32'h1234_5678}}, '0, "R8 all inactive");

    // R9 and R10: gap, then stable output
    @(negedge clk);
    held = result_o;
    check(valid_o === 1'b0, "R9 valid drops", {127'd0, valid_o}, '0);
    repeat (3) @(negedge clk);
    check(result_o === held, "R10 hold", result_o, held);

    // random, back to back and with gaps
    for (int i = 0; i < 400; i++) begin
      int sz, ew;
      logic [VB-1:0] dst, dat;
      logic [NB-1:0] pr;
      sz = $urandom_range(0, 3);
      ew = 8 << sz;
      for (int w = 0; w < VB / 32; w++) dat[w*32 +: 32] = $urandom();
      for (int k = 0; k < VB / ew; k++) begin
        logic [63:0] a;
        a = pick_amt(ew);
        for (int b = 0; b < ew; b++) dst[k*ew + b] = a[b];
      end
      pr = NB'($urandom());
      if ($urandom_range(0, 15) == 0) pr = '0;
      do_issue(sz, dst, dat, pr, "R2 random");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results seen", VB'(exp_q.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule